// File: doc/BRIEF.md
# Operand-Capturing Instruction Issue Window

This block is a small centralized instruction window that sits between decode and a set of functional units. Decode writes one instruction per cycle into a free slot. The slot holds the opcode, the destination register identifier, the number of the unit that will execute it, and two operand slots. Each operand slot holds either a value or the tag of the result that will produce that value. A result bus carries a tag and a value each cycle. Every waiting operand slot whose tag matches the bus takes the value.

When both operands of an instruction are present and its unit reports that it is free, the instruction leaves on that unit's issue port. It carries its opcode, destination and both operand values, so the unit never reads the register file. Operands are copied into the window, so a later write to the same architectural register cannot change a value that has already been captured. When several instructions wait for the same unit, the one that was allocated first goes first. A flush input empties the window in one cycle.

Top module: `issue_window`

## Requirements
- R1: An issued instruction presents, on the issue port of the unit named by its `alloc_fu` value, the opcode, destination identifier and operand values it was allocated or woken with.
- R2: An operand flagged ready at allocation is stored as the given value, and its tag is not used.
- R3: An operand not flagged ready waits on its tag. A broadcast with a matching tag stores the broadcast value, and the instruction can issue from the following cycle.
- R4: If an allocation arrives in the same cycle as a broadcast of one of its waiting tags, that operand takes the broadcast value.
- R5: Once an operand holds a value, later broadcasts with the same tag leave that value unchanged.
- R6: An instruction issues only when both of its operands hold values and its unit's `fu_busy` bit is 0. `iss_valid[u]` is 0 in every cycle where `fu_busy[u]` is 1.
- R7: Each unit issues at most one instruction per cycle. Among the instructions eligible for a unit, the one allocated earliest issues.
- R8: An issued instruction leaves the window at the clock edge that ends its issue cycle. If the window was full, `alloc_stall` falls in the following cycle.
- R9: `alloc_stall` is 1 exactly when every slot is occupied. While it is 1, `alloc_valid` is ignored and nothing is written.
- R10: A flush empties every slot at the next edge. In the flush cycle nothing issues and allocation is ignored.
- R11: After reset the window is empty: `alloc_stall` is 0 and every `iss_valid` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the window |
| alloc_valid | input | 1 | Decode presents an instruction |
| alloc_opc | input | OPC_W | Opcode |
| alloc_fu | input | FU_W | Target functional unit number |
| alloc_dst | input | DST_W | Destination register identifier |
| alloc_a_rdy | input | 1 | First operand value is present |
| alloc_a_tag | input | TAG_W | Producer tag of first operand |
| alloc_a_val | input | DATA_W | First operand value |
| alloc_b_rdy | input | 1 | Second operand value is present |
| alloc_b_tag | input | TAG_W | Producer tag of second operand |
| alloc_b_val | input | DATA_W | Second operand value |
| alloc_stall | output | 1 | Window full, allocation refused |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of broadcast result |
| bc_data | input | DATA_W | Broadcast result value |
| fu_busy | input | NUM_FU | Per-unit busy flags |
| iss_valid | output | NUM_FU | Per-unit issue strobe |
| iss_opc | output | NUM_FU x OPC_W | Issued opcode per unit |
| iss_dst | output | NUM_FU x DST_W | Issued destination per unit |
| iss_a | output | NUM_FU x DATA_W | Issued first operand per unit |
| iss_b | output | NUM_FU x DATA_W | Issued second operand per unit |

## Verification
A broadcast can land in the same cycle as an allocation that waits on its tag. It can also land one cycle after an operand has already captured a value under the same tag. Directed sequences set up both cases, and the random phase raises them often by drawing broadcast tags from a small tag space. A bench model updated once per cycle judges both: it predicts which value each operand must hold, and the check happens when that instruction later issues. Allocation and issue-driven freeing also coincide when the window is full; the model predicts the stall falling in the cycle after the issue.

// File: rtl/iw_pkg.sv
package iw_pkg;
   localparam int unsigned IW_DEPTH_DEF  = 4;
   localparam int unsigned IW_NUM_FU_DEF = 2;

   // index width that never collapses to zero bits
   function automatic int unsigned iw_idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/iw_operand.sv
module iw_operand #(
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              in_rdy,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [DATA_W-1:0] in_val,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic              rdy,
   output logic [DATA_W-1:0] val
);
   logic [TAG_W-1:0] tag_q;
   logic             hit_new;
   logic             hit_wait;

   assign hit_new  = bc_valid && (bc_tag == in_tag);
   assign hit_wait = bc_valid && !rdy && (bc_tag == tag_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy   <= 1'b0;
         tag_q <= '0;
         val   <= '0;
      end else if (load) begin
         tag_q <= in_tag;
         if (in_rdy) begin
            rdy <= 1'b1;
            val <= in_val;
         end else if (hit_new) begin
            rdy <= 1'b1;
            val <= bc_data;
         end else begin
            rdy <= 1'b0;
         end
      end else if (hit_wait) begin
         rdy <= 1'b1;
         val <= bc_data;
      end
   end

   // R5
   captured_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !load) |=> (rdy && $stable(val)));

   // R3
   wake_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !rdy && bc_valid && bc_tag == tag_q) |=> (rdy && val == $past(bc_data)));
endmodule

// File: rtl/iw_slot.sv
module iw_slot #(
   parameter int unsigned OPC_W  = 5,
   parameter int unsigned DST_W  = 5,
   parameter int unsigned FU_W   = 1,
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              alloc_we,
   input  logic              take,
   input  logic [OPC_W-1:0]  in_opc,
   input  logic [FU_W-1:0]   in_fu,
   input  logic [DST_W-1:0]  in_dst,
   input  logic              in_a_rdy,
   input  logic [TAG_W-1:0]  in_a_tag,
   input  logic [DATA_W-1:0] in_a_val,
   input  logic              in_b_rdy,
   input  logic [TAG_W-1:0]  in_b_tag,
   input  logic [DATA_W-1:0] in_b_val,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic              vld,
   output logic              ready,
   output logic [OPC_W-1:0]  opc,
   output logic [FU_W-1:0]   fu,
   output logic [DST_W-1:0]  dst,
   output logic [DATA_W-1:0] a_val,
   output logic [DATA_W-1:0] b_val
);
   localparam int unsigned N_OPND = 2;

   logic [N_OPND-1:0]             op_in_rdy;
   logic [N_OPND-1:0][TAG_W-1:0]  op_in_tag;
   logic [N_OPND-1:0][DATA_W-1:0] op_in_val;
   logic [N_OPND-1:0]             op_rdy;
   logic [N_OPND-1:0][DATA_W-1:0] op_val;

   assign op_in_rdy = {in_b_rdy, in_a_rdy};
   assign op_in_tag = {in_b_tag, in_a_tag};
   assign op_in_val = {in_b_val, in_a_val};

   for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
      iw_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) opnd_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (alloc_we),
         .in_rdy   (op_in_rdy[k]),
         .in_tag   (op_in_tag[k]),
         .in_val   (op_in_val[k]),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .bc_data  (bc_data),
         .rdy      (op_rdy[k]),
         .val      (op_val[k])
      );
   end

   assign ready = &op_rdy;
   assign a_val = op_val[0];
   assign b_val = op_val[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= 1'b0;
         opc <= '0;
         fu  <= '0;
         dst <= '0;
      end else begin
         if (flush)         vld <= 1'b0;
         else if (alloc_we) vld <= 1'b1;
         else if (take)     vld <= 1'b0;
         if (alloc_we) begin
            opc <= in_opc;
            fu  <= in_fu;
            dst <= in_dst;
         end
      end
   end

   // R9
   alloc_into_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_we |-> !vld);

   // R6
   take_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (vld && ready));

   // R8
   take_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !vld);
endmodule

// File: rtl/iw_age_matrix.sv
module iw_age_matrix #(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned NUM_FU = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [DEPTH-1:0]             alloc_we,
   input  logic [DEPTH-1:0]             vld,
   input  logic [NUM_FU-1:0][DEPTH-1:0] elig,
   output logic [NUM_FU-1:0][DEPTH-1:0] grant
);
   // older_q[i][j] set: slot i was written before slot j
   logic [DEPTH-1:0][DEPTH-1:0] older_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         older_q <= '0;
      end else begin
         for (int k = 0; k < DEPTH; k++) begin
            if (alloc_we[k]) begin
               for (int j = 0; j < DEPTH; j++) begin
                  if (j != k) begin
                     older_q[k][j] <= 1'b0;
                     older_q[j][k] <= 1'b1;
                  end
               end
            end
         end
      end
   end

   always_comb begin
      grant = '0;
      for (int u = 0; u < NUM_FU; u++) begin
         for (int i = 0; i < DEPTH; i++) begin
            grant[u][i] = elig[u][i];
            for (int j = 0; j < DEPTH; j++) begin
               if (j != i && elig[u][j] && older_q[j][i]) grant[u][i] = 1'b0;
            end
         end
      end
   end

   for (genvar u = 0; u < NUM_FU; u++) begin : g_unit_chk
      // R7
      one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(grant[u]));
      // R7
      grant_if_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|elig[u]) |-> (|grant[u]));
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_row_chk
      for (genvar j = i + 1; j < DEPTH; j++) begin : g_col_chk
         // R7
         total_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vld[i] && vld[j]) |-> (older_q[i][j] != older_q[j][i]));
      end
   end
endmodule

// File: rtl/issue_window.sv
module issue_window import iw_pkg::*; #(
   parameter int unsigned DEPTH  = IW_DEPTH_DEF,
   parameter int unsigned NUM_FU = IW_NUM_FU_DEF,
   parameter int unsigned OPC_W  = 5,
   parameter int unsigned DST_W  = 5,
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned FU_W  = iw_idx_w(NUM_FU)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          alloc_valid,
   input  logic [OPC_W-1:0]              alloc_opc,
   input  logic [FU_W-1:0]               alloc_fu,
   input  logic [DST_W-1:0]              alloc_dst,
   input  logic                          alloc_a_rdy,
   input  logic [TAG_W-1:0]              alloc_a_tag,
   input  logic [DATA_W-1:0]             alloc_a_val,
   input  logic                          alloc_b_rdy,
   input  logic [TAG_W-1:0]              alloc_b_tag,
   input  logic [DATA_W-1:0]             alloc_b_val,
   output logic                          alloc_stall,
   input  logic                          bc_valid,
   input  logic [TAG_W-1:0]              bc_tag,
   input  logic [DATA_W-1:0]             bc_data,
   input  logic [NUM_FU-1:0]             fu_busy,
   output logic [NUM_FU-1:0]             iss_valid,
   output logic [NUM_FU-1:0][OPC_W-1:0]  iss_opc,
   output logic [NUM_FU-1:0][DST_W-1:0]  iss_dst,
   output logic [NUM_FU-1:0][DATA_W-1:0] iss_a,
   output logic [NUM_FU-1:0][DATA_W-1:0] iss_b
);
   localparam int unsigned IDX_W = iw_idx_w(DEPTH);

   if (DEPTH < 2)  begin : g_bad_depth  $error("issue_window: DEPTH must be at least 2");  end
   if (NUM_FU < 1) begin : g_bad_units  $error("issue_window: NUM_FU must be at least 1"); end
   if (TAG_W < 1)  begin : g_bad_tag    $error("issue_window: TAG_W must be at least 1");  end
   if (DATA_W < 1) begin : g_bad_data   $error("issue_window: DATA_W must be at least 1"); end

   logic [DEPTH-1:0]              s_vld, s_rdy, alloc_we, take;
   logic [DEPTH-1:0][OPC_W-1:0]   s_opc;
   logic [DEPTH-1:0][FU_W-1:0]    s_fu;
   logic [DEPTH-1:0][DST_W-1:0]   s_dst;
   logic [DEPTH-1:0][DATA_W-1:0]  s_a, s_b;
   logic [NUM_FU-1:0][DEPTH-1:0]  elig, grant;
   logic [IDX_W-1:0]              free_idx;
   logic                          alloc_fire;

   assign alloc_stall = &s_vld;
   assign alloc_fire  = alloc_valid && !alloc_stall && !flush;

   // lowest free slot
   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!s_vld[i]) free_idx = IDX_W'(i);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign alloc_we[i] = alloc_fire && (free_idx == IDX_W'(i));

      iw_slot #(
         .OPC_W(OPC_W), .DST_W(DST_W), .FU_W(FU_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
      ) slot_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush),
         .alloc_we (alloc_we[i]),
         .take     (take[i]),
         .in_opc   (alloc_opc),
         .in_fu    (alloc_fu),
         .in_dst   (alloc_dst),
         .in_a_rdy (alloc_a_rdy),
         .in_a_tag (alloc_a_tag),
         .in_a_val (alloc_a_val),
         .in_b_rdy (alloc_b_rdy),
         .in_b_tag (alloc_b_tag),
         .in_b_val (alloc_b_val),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .bc_data  (bc_data),
         .vld      (s_vld[i]),
         .ready    (s_rdy[i]),
         .opc      (s_opc[i]),
         .fu       (s_fu[i]),
         .dst      (s_dst[i]),
         .a_val    (s_a[i]),
         .b_val    (s_b[i])
      );

      for (genvar u = 0; u < NUM_FU; u++) begin : g_elig
         assign elig[u][i] = s_vld[i] && s_rdy[i] && (s_fu[i] == FU_W'(u))
                             && !fu_busy[u] && !flush;
      end
   end

   iw_age_matrix #(.DEPTH(DEPTH), .NUM_FU(NUM_FU)) age_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_we (alloc_we),
      .vld      (s_vld),
      .elig     (elig),
      .grant    (grant)
   );

   always_comb begin
      take = '0;
      for (int u = 0; u < NUM_FU; u++) take = take | grant[u];
   end

   always_comb begin
      iss_valid = '0;
      iss_opc   = '0;
      iss_dst   = '0;
      iss_a     = '0;
      iss_b     = '0;
      for (int u = 0; u < NUM_FU; u++) begin
         iss_valid[u] = |grant[u];
         for (int i = 0; i < DEPTH; i++) begin
            if (grant[u][i]) begin
               iss_opc[u] = iss_opc[u] | s_opc[i];
               iss_dst[u] = iss_dst[u] | s_dst[i];
               iss_a[u]   = iss_a[u]   | s_a[i];
               iss_b[u]   = iss_b[u]   | s_b[i];
            end
         end
      end
   end

   // R9
   no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_stall |-> (alloc_we == '0));

   // R9
   single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(alloc_we));

   // R10
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!alloc_stall && s_vld == '0));

   // R10
   flush_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (iss_valid == '0));

   for (genvar u = 0; u < NUM_FU; u++) begin : g_busy_chk
      // R6
      busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fu_busy[u] |-> !iss_valid[u]);
   end
endmodule

// File: tb/issue_window_tb_top.sv
module issue_window_tb_top;
   localparam int unsigned DEPTH  = 4;
   localparam int unsigned NUM_FU = 2;
   localparam int unsigned OPC_W  = 5;
   localparam int unsigned DST_W  = 5;
   localparam int unsigned TAG_W  = 4;
   localparam int unsigned DATA_W = 16;
   localparam int unsigned FU_W   = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic alloc_valid = 1'b0;
   logic [OPC_W-1:0]  alloc_opc = '0;
   logic [FU_W-1:0]   alloc_fu = '0;
   logic [DST_W-1:0]  alloc_dst = '0;
   logic              alloc_a_rdy = 1'b0, alloc_b_rdy = 1'b0;
   logic [TAG_W-1:0]  alloc_a_tag = '0, alloc_b_tag = '0;
   logic [DATA_W-1:0] alloc_a_val = '0, alloc_b_val = '0;
   logic              alloc_stall;
   logic              bc_valid = 1'b0;
   logic [TAG_W-1:0]  bc_tag = '0;
   logic [DATA_W-1:0] bc_data = '0;
   logic [NUM_FU-1:0] fu_busy = '0;
   logic [NUM_FU-1:0] iss_valid;
   logic [NUM_FU-1:0][OPC_W-1:0]  iss_opc;
   logic [NUM_FU-1:0][DST_W-1:0]  iss_dst;
   logic [NUM_FU-1:0][DATA_W-1:0] iss_a, iss_b;

   always #4 clk = ~clk;

   issue_window #(
      .DEPTH(DEPTH), .NUM_FU(NUM_FU), .OPC_W(OPC_W), .DST_W(DST_W),
      .TAG_W(TAG_W), .DATA_W(DATA_W)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .alloc_valid(alloc_valid), .alloc_opc(alloc_opc), .alloc_fu(alloc_fu),
      .alloc_dst(alloc_dst), .alloc_a_rdy(alloc_a_rdy), .alloc_a_tag(alloc_a_tag),
      .alloc_a_val(alloc_a_val), .alloc_b_rdy(alloc_b_rdy), .alloc_b_tag(alloc_b_tag),
      .alloc_b_val(alloc_b_val), .alloc_stall(alloc_stall),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
      .fu_busy(fu_busy), .iss_valid(iss_valid), .iss_opc(iss_opc),
      .iss_dst(iss_dst), .iss_a(iss_a), .iss_b(iss_b)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // reference model: slots with allocation sequence numbers
   bit                m_v   [DEPTH];
   int unsigned       m_seq [DEPTH];
   logic [OPC_W-1:0]  m_opc [DEPTH];
   logic [FU_W-1:0]   m_fu  [DEPTH];
   logic [DST_W-1:0]  m_dst [DEPTH];
   bit                m_ar  [DEPTH], m_br [DEPTH];
   logic [TAG_W-1:0]  m_at  [DEPTH], m_bt [DEPTH];
   logic [DATA_W-1:0] m_av  [DEPTH], m_bv [DEPTH];
   int unsigned       seq_ctr = 0;

   function automatic int count_valid();
      int c = 0;
      for (int i = 0; i < DEPTH; i++) if (m_v[i]) c++;
      return c;
   endfunction

   function automatic int pick_oldest(input int u);
      int best = -1;
      for (int i = 0; i < DEPTH; i++) begin
         if (m_v[i] && m_ar[i] && m_br[i] && m_fu[i] == FU_W'(u) && !fu_busy[u] && !flush)
            if (best < 0 || m_seq[i] < m_seq[best]) best = i;
      end
      return best;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint got, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic idle();
      alloc_valid = 1'b0;
      bc_valid    = 1'b0;
      flush       = 1'b0;
   endtask

   task automatic set_alloc(input int fu, input int opc, input int dst,
                            input bit ar, input int at, input int av,
                            input bit br, input int bt, input int bv);
      alloc_valid = 1'b1;
      alloc_fu    = FU_W'(fu);
      alloc_opc   = OPC_W'(opc);
      alloc_dst   = DST_W'(dst);
      alloc_a_rdy = ar; alloc_a_tag = TAG_W'(at); alloc_a_val = DATA_W'(av);
      alloc_b_rdy = br; alloc_b_tag = TAG_W'(bt); alloc_b_val = DATA_W'(bv);
   endtask

   task automatic set_bc(input int tag, input int data);
      bc_valid = 1'b1;
      bc_tag   = TAG_W'(tag);
      bc_data  = DATA_W'(data);
   endtask

   // one clock: check outputs mid-cycle, advance the model, return after the edge
   task automatic cycle();
      int  pick [NUM_FU];
      int  slot;
      bit  exp_stall;
      @(negedge clk);
      #1;
      exp_stall = (count_valid() == DEPTH);
      chk(alloc_stall == exp_stall, "R9", "alloc_stall", alloc_stall, exp_stall);
      for (int u = 0; u < NUM_FU; u++) begin
         pick[u] = pick_oldest(u);
         chk(iss_valid[u] == (pick[u] >= 0), "R7", $sformatf("iss_valid[%0d]", u),
             iss_valid[u], pick[u] >= 0);
         if (pick[u] >= 0 && iss_valid[u]) begin
            chk(iss_opc[u] == m_opc[pick[u]], "R1", "iss_opc", iss_opc[u], m_opc[pick[u]]);
            chk(iss_dst[u] == m_dst[pick[u]], "R1", "iss_dst", iss_dst[u], m_dst[pick[u]]);
            chk(iss_a[u] == m_av[pick[u]], "R5", "iss_a", iss_a[u], m_av[pick[u]]);
            chk(iss_b[u] == m_bv[pick[u]], "R5", "iss_b", iss_b[u], m_bv[pick[u]]);
         end
      end
      // model update for the coming edge
      if (flush) begin
         for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
      end else begin
         slot = -1;
         if (alloc_valid && !exp_stall)
            for (int i = DEPTH - 1; i >= 0; i--) if (!m_v[i]) slot = i;
         for (int u = 0; u < NUM_FU; u++) if (pick[u] >= 0) m_v[pick[u]] = 1'b0;
         if (bc_valid) begin
            for (int i = 0; i < DEPTH; i++) begin
               if (!m_ar[i] && m_at[i] == bc_tag) begin m_ar[i] = 1'b1; m_av[i] = bc_data; end
               if (!m_br[i] && m_bt[i] == bc_tag) begin m_br[i] = 1'b1; m_bv[i] = bc_data; end
            end
         end
         if (slot >= 0) begin
            m_v[slot]   = 1'b1;
            m_seq[slot] = seq_ctr++;
            m_opc[slot] = alloc_opc;
            m_fu[slot]  = alloc_fu;
            m_dst[slot] = alloc_dst;
            m_at[slot]  = alloc_a_tag;
            m_bt[slot]  = alloc_b_tag;
            m_ar[slot]  = alloc_a_rdy || (bc_valid && bc_tag == alloc_a_tag);
            m_av[slot]  = alloc_a_rdy ? alloc_a_val : bc_data;
            m_br[slot]  = alloc_b_rdy || (bc_valid && bc_tag == alloc_b_tag);
            m_bv[slot]  = alloc_b_rdy ? alloc_b_val : bc_data;
         end
      end
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(8 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R11: reset state while reset is held
      @(negedge clk);
      #1;
      chk(alloc_stall == 1'b0, "R11", "alloc_stall in reset", alloc_stall, 0);
      chk(iss_valid == '0, "R11", "iss_valid in reset", iss_valid, 0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      cycle();

      // R1 R2: both operands given at allocation, unit 0 free, issues next cycle
      set_alloc(0, 5'h0a, 5'h11, 1, 3, 16'h1234, 1, 4, 16'h5678);
      cycle();
      idle();
      cycle();
      cycle();

      // R4: allocation with tag 6 while tag 6 is broadcast
      set_alloc(1, 5'h03, 5'h02, 0, 6, 0, 1, 0, 16'h0042);
      set_bc(6, 16'hbeef);
      cycle();
      idle();
      cycle();

      // R3 R5 R6: wait on tag 9 with unit busy, wake, then overwrite attempt
      fu_busy = 2'b01;
      set_alloc(0, 5'h07, 5'h05, 0, 9, 0, 0, 10, 0);
      cycle();
      idle();
      set_bc(9, 16'h1111);
      cycle();
      set_bc(10, 16'h2222);
      cycle();
      set_bc(9, 16'h9999);
      cycle();
      idle();
      fu_busy = 2'b00;
      cycle();
      cycle();

      // R7: three ready entries for unit 1 while busy, then oldest first
      fu_busy = 2'b10;
      for (int k = 0; k < 3; k++) begin
         set_alloc(1, 5'h10 + k, k, 1, 0, 16'h100 + k, 1, 0, 16'h200 + k);
         cycle();
      end
      idle();
      fu_busy = 2'b00;
      repeat (4) cycle();

      // R9 R8: fill the window, refused allocation, then free one slot
      fu_busy = 2'b11;
      for (int k = 0; k < DEPTH + 1; k++) begin
         set_alloc(k % 2, k, k + 8, 1, 0, 16'h300 + k, 1, 0, 16'h400 + k);
         cycle();
      end
      idle();
      fu_busy = 2'b01;
      cycle();
      cycle();
      fu_busy = 2'b00;
      repeat (4) cycle();

      // R10: flush a populated window while an allocation is offered
      fu_busy = 2'b11;
      set_alloc(0, 1, 1, 1, 0, 16'h55, 1, 0, 16'h66);
      cycle();
      cycle();
      set_alloc(1, 2, 2, 1, 0, 16'h77, 1, 0, 16'h88);
      flush = 1'b1;
      cycle();
      idle();
      fu_busy = 2'b00;
      repeat (3) cycle();

      // constrained random phase
      for (int n = 0; n < 4000; n++) begin
         alloc_valid = ($urandom_range(0, 9) < 6);
         alloc_fu    = FU_W'($urandom_range(0, NUM_FU - 1));
         alloc_opc   = OPC_W'($urandom);
         alloc_dst   = DST_W'($urandom);
         alloc_a_rdy = $urandom_range(0, 1);
         alloc_a_tag = TAG_W'($urandom_range(0, 5));
         alloc_a_val = DATA_W'($urandom);
         alloc_b_rdy = $urandom_range(0, 1);
         alloc_b_tag = TAG_W'($urandom_range(0, 5));
         alloc_b_val = DATA_W'($urandom);
         bc_valid    = ($urandom_range(0, 9) < 4);
         bc_tag      = TAG_W'($urandom_range(0, 5));
         bc_data     = DATA_W'($urandom);
         fu_busy     = NUM_FU'($urandom_range(0, 3) == 0 ? 2'b11 : $urandom_range(0, 2));
         flush       = ($urandom_range(0, 99) < 2);
         cycle();
      end
      idle();
      fu_busy = '0;
      repeat (6) cycle();

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule